// File: doc/BRIEF.md
# Reloadable Down-Counter with Masked Compare

This block is a timer that counts down by one on every cycle in which a prescaled tick enable is high. When it leaves zero it reloads. A select bit chooses the reload value: all ones, or a programmable reload register. With the select bit set, a rising edge on either of two capture event inputs also forces a reload from the reload register. The running count is compared continuously against zero and against a compare register. Only the bit positions set in a mask register take part in the comparison, so with a low-order mask the matches repeat at power-of-two sub-periods of the full count.

Three sticky flags record underflow reloads, masked zero matches and masked compare matches. Software clears a flag by writing 1 to its bit. The register port is a simple write strobe with an address. The read data is combinational from the address. The prescaler divider, pin synchronisation and interrupt generation belong to neighbouring blocks.

Top module: `mask_down_timer`

## Requirements
- R1: After reset the count is 0000h, all flags are 0, the run and select bits are 0, the reload and mask registers read FFFFh and the compare register reads 0000h.
- R2: While the run bit (control bit 0) is 0, the count is 0000h on the following cycle and stays there, whatever the tick and capture inputs do.
- R3: While running, the count decrements by exactly one on each cycle with `tick` high, and holds on cycles with `tick` low, unless a reload applies.
- R4: With the select bit (control bit 1) at 0, a tick at count 0000h loads FFFFh, so the count repeats every 65536 ticks.
- R5: With the select bit at 1, a tick at count 0000h loads the reload register, so the count repeats every reload+1 ticks.
- R6: With the select bit at 1 and running, a 0-to-1 transition on either bit of `cap_evt` reloads the count from the reload register on the next edge, independent of `tick`. A level held high does not retrigger. With the select bit at 0, edges are ignored.
- R7: A capture edge in the same cycle as a tick at zero causes a single reload from the reload register.
- R8: Every tick at count 0000h while running sets the overflow flag (control bit 2).
- R9: `zero_hit` is high while running when (mask AND count) equals 0. Each such cycle sets the zero flag (control bit 3).
- R10: `cmp_hit` is high while running when (mask AND count) equals (mask AND compare). Each such cycle sets the compare flag (control bit 4).
- R11: Flags are sticky. A control write with 1 in a flag bit clears that flag, and 0 leaves it. A set in the same cycle as a clear wins.
- R12: With a mask of 2^(n+1)-1 and one tick per cycle, `zero_hit` and `cmp_hit` are each high once in every 2^(n+1) cycles. A mask of 0 makes every count match.
- R13: Read addresses are 0 control/flags, 1 reload, 2 compare, 3 mask and 4 count. Other addresses read 0. Writes take effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| tick | input | 1 | Prescaled count enable |
| cap_evt | input | 2 | Capture event inputs, already synchronised |
| count_o | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky underflow-reload flag |
| zero_flag | output | 1 | Sticky masked-zero flag |
| cmp_flag | output | 1 | Sticky masked-compare flag |
| zero_hit | output | 1 | Masked zero match this cycle |
| cmp_hit | output | 1 | Masked compare match this cycle |

## Verification
The bench builds the block with its default 16-bit count and two capture inputs. At that width a full all-ones wrap of 65536 ticks fits in the run, so R4 is checked over its true period rather than a scaled one. A short reload value of 9 makes the R5 period and the R7 coincidence of a capture edge with an underflow easy to line up. Low-order masks of 3 and 0 expose the sub-period repetition of R12 in a few dozen cycles. A pseudo-random phase with sparse ticks, random capture edges and wandering read addresses compares every output against a behavioural model on each clock.

// File: rtl/mdt_pkg.sv
package mdt_pkg;

    localparam int CNT_W_DEF = 16;
    localparam int EVT_N_DEF = 2;
    localparam int ADR_W_DEF = 3;

    // control / flag bit positions in the control word
    localparam int B_RUN  = 0;
    localparam int B_SEL  = 1;
    localparam int B_OVF  = 2;
    localparam int B_ZERO = 3;
    localparam int B_CMP  = 4;

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_RELOAD = 3'd1,
        A_CMP    = 3'd2,
        A_MASK   = 3'd3,
        A_COUNT  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic sel;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic cmp;
        logic zero;
        logic ovf;
    } flags_t;

    typedef struct packed {
        logic cmp;
        logic zero;
        logic uflow;
    } events_t;

    function automatic logic flag_next(input logic cur, input logic clr, input logic set);
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/mdt_edge.sv
module mdt_edge #(
    parameter int NEV = mdt_pkg::EVT_N_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NEV-1:0] evt_in,
    output logic           any_rise
);
    logic [NEV-1:0] rise;

    for (genvar g = 0; g < NEV; g++) begin : g_det
        logic prev_q;
        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= evt_in[g];
        end
        assign rise[g] = evt_in[g] & ~prev_q;
    end

    assign any_rise = |rise;
endmodule

// File: rtl/mdt_core.sv
module mdt_core import mdt_pkg::*; #(
    parameter int CW = CNT_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         ctrl,
    input  logic          tick,
    input  logic          evt_reload,
    input  logic [CW-1:0] reload_val,
    input  logic [CW-1:0] cmp_val,
    input  logic [CW-1:0] mask_val,
    output logic [CW-1:0] count,
    output events_t       ev
);
    localparam logic [CW-1:0] ALL_ONES = '1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] reload_pick;
    logic          at_zero;
    logic          uflow;

    assign at_zero     = (cnt_q == '0);
    assign uflow       = ctrl.run & tick & at_zero;
    assign reload_pick = ctrl.sel ? reload_val : ALL_ONES;

    always_ff @(posedge clk) begin
        if (rst || !ctrl.run)        cnt_q <= '0;
        else if (uflow || evt_reload) cnt_q <= reload_pick;
        else if (tick)               cnt_q <= cnt_q - 1'b1;
    end

    assign count    = cnt_q;
    assign ev.uflow = uflow;
    assign ev.zero  = ctrl.run & ((cnt_q & mask_val) == '0);
    assign ev.cmp   = ctrl.run & ((cnt_q & mask_val) == (cmp_val & mask_val));
endmodule

// File: rtl/mdt_regs.sv
module mdt_regs import mdt_pkg::*; #(
    parameter int CW = CNT_W_DEF,
    parameter int AW = ADR_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata,
    input  logic [CW-1:0] count,
    input  events_t       ev,
    output ctrl_t         ctrl,
    output logic [CW-1:0] reload_val,
    output logic [CW-1:0] cmp_val,
    output logic [CW-1:0] mask_val,
    output flags_t        flags
);
    logic   wr_ctrl;
    flags_t clr;

    assign wr_ctrl  = we && (addr == AW'(A_CTRL));
    assign clr.ovf  = wr_ctrl & wdata[B_OVF];
    assign clr.zero = wr_ctrl & wdata[B_ZERO];
    assign clr.cmp  = wr_ctrl & wdata[B_CMP];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl       <= '0;
            reload_val <= '1;
            cmp_val    <= '0;
            mask_val   <= '1;
            flags      <= '0;
        end else begin
            flags.ovf  <= flag_next(flags.ovf,  clr.ovf,  ev.uflow);
            flags.zero <= flag_next(flags.zero, clr.zero, ev.zero);
            flags.cmp  <= flag_next(flags.cmp,  clr.cmp,  ev.cmp);
            if (wr_ctrl) begin
                ctrl.run <= wdata[B_RUN];
                ctrl.sel <= wdata[B_SEL];
            end
            if (we && addr == AW'(A_RELOAD)) reload_val <= wdata;
            if (we && addr == AW'(A_CMP))    cmp_val    <= wdata;
            if (we && addr == AW'(A_MASK))   mask_val   <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            AW'(A_CTRL): begin
                rdata[B_RUN]  = ctrl.run;
                rdata[B_SEL]  = ctrl.sel;
                rdata[B_OVF]  = flags.ovf;
                rdata[B_ZERO] = flags.zero;
                rdata[B_CMP]  = flags.cmp;
            end
            AW'(A_RELOAD): rdata = reload_val;
            AW'(A_CMP):    rdata = cmp_val;
            AW'(A_MASK):   rdata = mask_val;
            AW'(A_COUNT):  rdata = count;
            default:       rdata = '0;
        endcase
    end
endmodule

// File: rtl/mask_down_timer.sv
module mask_down_timer import mdt_pkg::*; #(
    parameter int CW  = CNT_W_DEF,
    parameter int NEV = EVT_N_DEF,
    parameter int AW  = ADR_W_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [CW-1:0]  reg_wdata,
    output logic [CW-1:0]  reg_rdata,
    input  logic           tick,
    input  logic [NEV-1:0] cap_evt,
    output logic [CW-1:0]  count_o,
    output logic           ovf_flag,
    output logic           zero_flag,
    output logic           cmp_flag,
    output logic           zero_hit,
    output logic           cmp_hit
);
    ctrl_t         ctrl;
    flags_t        flags;
    events_t       ev;
    logic [CW-1:0] reload_q, cmp_q, mask_q;
    logic          cap_rise;
    logic          evt_reload;

    mdt_edge #(.NEV(NEV)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .evt_in   (cap_evt),
        .any_rise (cap_rise)
    );

    assign evt_reload = ctrl.run & ctrl.sel & cap_rise;

    mdt_core #(.CW(CW)) u_core (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .tick       (tick),
        .evt_reload (evt_reload),
        .reload_val (reload_q),
        .cmp_val    (cmp_q),
        .mask_val   (mask_q),
        .count      (count_o),
        .ev         (ev)
    );

    mdt_regs #(.CW(CW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .count      (count_o),
        .ev         (ev),
        .ctrl       (ctrl),
        .reload_val (reload_q),
        .cmp_val    (cmp_q),
        .mask_val   (mask_q),
        .flags      (flags)
    );

    assign ovf_flag  = flags.ovf;
    assign zero_flag = flags.zero;
    assign cmp_flag  = flags.cmp;
    assign zero_hit  = ev.zero;
    assign cmp_hit   = ev.cmp;
endmodule

// File: rtl/mdt_chk.sv
module mdt_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          run,
    input logic          sel,
    input logic          tick,
    input logic          evt_reload,
    input logic [CW-1:0] count_o,
    input logic [CW-1:0] reload_q,
    input logic          ovf_flag,
    input logic          zero_flag,
    input logic          zero_hit,
    input logic          ovf_clr
);
    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (count_o == '0));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && count_o != '0 && !evt_reload) |=> (count_o == CW'($past(count_o) - 1'b1)));

    // R3
    no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !tick && !evt_reload) |=> $stable(count_o));

    // R4
    wrap_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && count_o == '0 && !sel) |=> (count_o == {CW{1'b1}}));

    // R5
    wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && count_o == '0 && sel) |=> (count_o == $past(reload_q)));

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && count_o == '0) |=> ovf_flag);

    // R9
    zero_set_chk: assert property (@(posedge clk) disable iff (rst)
        zero_hit |=> zero_flag);

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

bind mask_down_timer mdt_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (ctrl.run),
    .sel        (ctrl.sel),
    .tick       (tick),
    .evt_reload (evt_reload),
    .count_o    (count_o),
    .reload_q   (reload_q),
    .ovf_flag   (ovf_flag),
    .zero_flag  (zero_flag),
    .zero_hit   (zero_hit),
    .ovf_clr    (reg_we && (reg_addr == 3'd0) && reg_wdata[2])
);

// File: tb/mask_down_timer_tb_top.sv
module mask_down_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        tick = 1'b0;
    logic [1:0]  cap_evt = 2'b00;
    logic [15:0] count_o;
    logic        ovf_flag, zero_flag, cmp_flag, zero_hit, cmp_hit;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mask_down_timer dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
        .cap_evt(cap_evt), .count_o(count_o), .ovf_flag(ovf_flag),
        .zero_flag(zero_flag), .cmp_flag(cmp_flag), .zero_hit(zero_hit),
        .cmp_hit(cmp_hit)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_cnt, m_rl, m_cmp, m_mask, m_next;
    bit          m_run, m_sel, m_ovf, m_zf, m_cf;
    logic [1:0]  m_prev;
    bit          m_ev, m_uf, m_zh, m_ch;
    logic [2:0]  m_clr;

    function automatic bit mz(input logic [15:0] c, input logic [15:0] m, input bit r);
        return r && ((c & m) == 16'h0);
    endfunction
    function automatic bit mc(input logic [15:0] c, input logic [15:0] k, input logic [15:0] m, input bit r);
        return r && ((c & m) == (k & m));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_rl = 16'hFFFF; m_cmp = 0; m_mask = 16'hFFFF;
            m_run = 0; m_sel = 0; m_ovf = 0; m_zf = 0; m_cf = 0; m_prev = 0;
        end else begin
            m_ev  = m_run && m_sel && ((cap_evt & ~m_prev) != 2'b00);
            m_uf  = m_run && tick && (m_cnt == 16'h0);
            m_zh  = mz(m_cnt, m_mask, m_run);
            m_ch  = mc(m_cnt, m_cmp, m_mask, m_run);
            m_clr = (reg_we && reg_addr == 3'd0) ? reg_wdata[4:2] : 3'b000;
            m_ovf = (m_ovf && !m_clr[0]) || m_uf;
            m_zf  = (m_zf  && !m_clr[1]) || m_zh;
            m_cf  = (m_cf  && !m_clr[2]) || m_ch;
            if (!m_run)            m_next = 16'h0;
            else if (m_uf || m_ev) m_next = m_sel ? m_rl : 16'hFFFF;
            else if (tick)         m_next = m_cnt - 16'd1;
            else                   m_next = m_cnt;
            m_prev = cap_evt;
            if (reg_we) begin
                case (reg_addr)
                    3'd0: begin m_run = reg_wdata[0]; m_sel = reg_wdata[1]; end
                    3'd1: m_rl = reg_wdata;
                    3'd2: m_cmp = reg_wdata;
                    3'd3: m_mask = reg_wdata;
                    default: ;
                endcase
            end
            m_cnt = m_next;
        end
    end

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {11'h0, m_cf, m_zf, m_ovf, m_sel, m_run};
            3'd1: return m_rl;
            3'd2: return m_cmp;
            3'd3: return m_mask;
            3'd4: return m_cnt;
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (cmp_on && !rst && !done) begin
            chk("R3 count vs model", count_o, m_cnt);
            chk("R8 ovf flag vs model", {15'h0, ovf_flag}, {15'h0, m_ovf});
            chk("R9 zero flag vs model", {15'h0, zero_flag}, {15'h0, m_zf});
            chk("R10 cmp flag vs model", {15'h0, cmp_flag}, {15'h0, m_cf});
            chk("R9 zero_hit vs model", {15'h0, zero_hit}, {15'h0, mz(m_cnt, m_mask, m_run)});
            chk("R10 cmp_hit vs model", {15'h0, cmp_hit}, {15'h0, mc(m_cnt, m_cmp, m_mask, m_run)});
            chk("R13 read data vs model", reg_rdata, m_read(reg_addr));
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired act=%0d exp<=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
        reg_addr = a;
        #2;
        chk(req, reg_rdata, exp);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] snap;
    int hz, hc;

    initial begin
        steps(3);
        rst = 1'b0;
        cmp_on = 1'b1;
        @(negedge clk); #2;
        // R1 reset state
        chk("R1 count after reset", count_o, 16'h0);
        chk("R1 flags after reset", {13'h0, cmp_flag, zero_flag, ovf_flag}, 16'h0);
        rd_chk("R1 ctrl after reset", 3'd0, 16'h0);
        rd_chk("R1 reload after reset", 3'd1, 16'hFFFF);
        rd_chk("R1 compare after reset", 3'd2, 16'h0);
        rd_chk("R1 mask after reset", 3'd3, 16'hFFFF);
        rd_chk("R13 unused address", 3'd6, 16'h0);

        // R2 stopped: ticks and events do nothing
        tick = 1'b1;
        @(negedge clk); cap_evt = 2'b01;
        @(negedge clk); cap_evt = 2'b10;
        steps(3); #2;
        chk("R2 held at zero while stopped", count_o, 16'h0);
        cap_evt = 2'b00;

        // R4 / R3 / R8: run, select 0
        wr(3'd0, 16'h0001);
        @(negedge clk); #2;
        chk("R4 first underflow loads FFFF", count_o, 16'hFFFF);
        chk("R8 ovf set on underflow", {15'h0, ovf_flag}, 16'h1);
        steps(10); #2;
        chk("R3 ten ticks down", count_o, 16'hFFF5);
        tick = 1'b0;
        steps(4); #2;
        chk("R3 holds without tick", count_o, 16'hFFF5);
        tick = 1'b1;
        steps(65525); #2;
        chk("R4 reaches zero after 65535", count_o, 16'h0);
        @(negedge clk); #2;
        chk("R4 wraps to FFFF at 65536", count_o, 16'hFFFF);

        // R11 flag clearing
        wr(3'd0, 16'h0001);
        chk("R11 writing 0 keeps ovf", {15'h0, ovf_flag}, 16'h1);
        wr(3'd3, 16'h0000);
        wr(3'd0, 16'h001D);
        chk("R11 set wins over clear", {15'h0, zero_flag}, 16'h1);
        wr(3'd3, 16'hFFFF);
        wr(3'd0, 16'h001D);
        chk("R11 flags cleared by write", {13'h0, cmp_flag, zero_flag, ovf_flag}, 16'h0);

        // R6 / R5 with select 1
        wr(3'd1, 16'd9);
        wr(3'd0, 16'h0003);
        cap_evt = 2'b10;
        @(negedge clk); #2;
        chk("R6 capture edge reloads", count_o, 16'd9);
        @(negedge clk); #2;
        chk("R6 held level no retrigger", count_o, 16'd8);
        cap_evt = 2'b00;
        steps(8); #2;
        chk("R5 reaches zero", count_o, 16'd0);
        @(negedge clk); #2;
        chk("R5 underflow loads reload", count_o, 16'd9);
        steps(10); #2;
        chk("R5 period reload+1", count_o, 16'd9);

        // R7 coincident event and underflow
        wr(3'd0, 16'h0007);
        steps(7); #2;
        chk("R7 at zero before event", count_o, 16'd0);
        chk("R7 ovf cleared", {15'h0, ovf_flag}, 16'h0);
        cap_evt = 2'b01;
        @(negedge clk); #2;
        chk("R7 single reload", count_o, 16'd9);
        chk("R8 ovf on coincident underflow", {15'h0, ovf_flag}, 16'h1);
        @(negedge clk); #2;
        chk("R7 continues down", count_o, 16'd8);
        cap_evt = 2'b00;

        // R12 sub-period matches
        wr(3'd3, 16'h0003);
        wr(3'd2, 16'h0001);
        wr(3'd1, 16'd15);
        hz = 0; hc = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); #2;
            if (zero_hit) hz++;
            if (cmp_hit) hc++;
        end
        chk("R12 zero hits every 4", 16'(hz), 16'd8);
        chk("R12 cmp hits every 4 (R10)", 16'(hc), 16'd8);
        wr(3'd3, 16'h0000);
        hz = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #2;
            if (zero_hit) hz++;
        end
        chk("R12 mask zero matches always", 16'(hz), 16'd8);

        // pseudo-random phase, model compared each cycle
        wr(3'd3, 16'h000F);
        wr(3'd2, 16'h0005);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick = lfsr[0] & lfsr[3];
            cap_evt = (lfsr[7:4] == 4'h0) ? lfsr[9:8] : 2'b00;
            reg_addr = lfsr[12:10];
            reg_we = (lfsr[15:11] == 5'h1F);
            reg_wdata = {11'h0, lfsr[4:2], lfsr[1], 1'b1};
        end
        reg_we = 1'b0; cap_evt = 2'b00; tick = 1'b1;

        // R6 edges ignored with select 0
        wr(3'd3, 16'hFFFF);
        wr(3'd0, 16'h0001);
        steps(2); #2;
        snap = count_o;
        cap_evt = 2'b01;
        @(negedge clk); #2;
        chk("R6 edge ignored when select 0", count_o, (snap == 16'h0) ? 16'hFFFF : snap - 16'd1);
        cap_evt = 2'b00;

        // R2 stop clears count
        wr(3'd0, 16'h0000);
        cap_evt = 2'b11;
        steps(4); #2;
        chk("R2 count cleared on stop", count_o, 16'h0);
        rd_chk("R13 count readback", 3'd4, 16'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule